// File: doc/BRIEF.md
# Calendar Clock with Deferred Register Commit

This block keeps wall-clock time and a calendar date in hardware. It holds seconds, minutes, hours, day of month, month and a six-bit year counted from 1970. A slow timebase drives the count. Software selects that timebase through a guarded control word: either every pulse of an external slow oscillator, or pulses of an internal oscillator divided by a programmable ratio. A parameterised number of slow ticks makes one second.

Software sets the time and the date through a simple synchronous register bus. These writes do not land at once. An accepted write to either register raises that register's own in-progress flag in the control word. The new value is held aside and loaded on a later slow tick, and only then does the flag drop. Software polls the flags before it writes again.

The count advances on its own while software reads it, so the time and date registers can change between two reads. A caller that needs a consistent pair reads them twice and compares the results.

Top module: `cal_clock`

## Requirements
- R1: After reset, the control word (0x00) reads 0, the prescaler (0x08) reads 0, the time register (0x14) reads 0, and the date register (0x10) reads 0x00000101 (day 1, month 1, year offset 0, leap flag 0).
- R2: A write to 0x00 changes the control word only when write data bits [31:16] equal 0x16AA. Any other upper half leaves it unchanged. Bit 0 is the only stored bit, and bits [31:16] read as 0.
- R3: With control bit 0 set, each external oscillator pulse is one slow tick and internal pulses have no effect. With it clear, every (P+1)-th internal pulse is a slow tick, where P is the prescaler value held in bits [4:0] of 0x08, and external pulses have no effect.
- R4: The seconds count advances once for every SLOW_PER_SEC slow ticks.
- R5: An accepted write to the time register sets control bit 8. An accepted write to the date register sets control bit 7. Control bit 9 always reads 0.
- R6: A pending time or date value becomes readable, and its flag clears, on the third slow tick after the write (COMMIT_TICKS). Until then, the register reads its old contents. On that tick, the loaded value takes precedence over any advance.
- R7: A write to the time or date register while its own flag is set is ignored.
- R8: The time register packs seconds in [5:0], minutes in [13:8] and hours in [20:16]. Seconds roll over from 59 to 0 with a carry into minutes, minutes roll over from 59 to 0 with a carry into hours, and hours roll over from 23 to 0 with a carry into the day.
- R9: The date register packs the day in [4:0], the month (1 to 12) in [11:8], the year offset in [21:16] and the leap flag in bit 22. After the last day of a month the day returns to 1 and the month advances. Months 4, 6, 9 and 11 have 30 days, month 2 has 29 days with the leap flag set and 28 without it, and all other months have 31 days.
- R10: After day 31 of month 12, the month becomes 1 and the year offset increments, wrapping from 63 to 0. The leap flag is then set exactly when (year offset + 1970) is divisible by 4.
- R11: Read data is registered. It reflects the addressed register in the cycle after the read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWr | input | 1 | Write strobe |
| busRd | input | 1 | Read strobe |
| busAddr | input | 8 | Byte address of the register |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Registered read data |
| intOscEn | input | 1 | One-cycle pulse per internal oscillator period |
| extOscEn | input | 1 | One-cycle pulse per external oscillator period |

## Verification
Read data is due one clock after the read strobe, so the bench samples it at the falling edge that follows. Control and prescaler writes are seen by the next read. A time or date write shows up only after the third slow pulse the bench issues, so the bench reads the register once after two pulses and again after the third. The bench keeps its own count of slow-tick phase modulo SLOW_PER_SEC. With that count it places each rollover check on the exact pulse that produces the second tick, which lets it sweep every month length, with and without the leap flag, and the year wrap.

// File: rtl/cal_pkg.sv
package cal_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;
  localparam logic [15:0] CTRL_KEY = 16'h16AA;
  localparam logic [ADDR_W-1:0] ADDR_CTRL  = 8'h00;
  localparam logic [ADDR_W-1:0] ADDR_PRESC = 8'h08;
  localparam logic [ADDR_W-1:0] ADDR_DATE  = 8'h10;
  localparam logic [ADDR_W-1:0] ADDR_TIME  = 8'h14;
  localparam int PRESC_W = 5;

  typedef struct packed {
    logic [4:0] hour;
    logic [5:0] min;
    logic [5:0] sec;
  } calTime_t;

  typedef struct packed {
    logic       leap;
    logic [5:0] year;
    logic [3:0] month;
    logic [4:0] day;
  } calDate_t;

  // strobes from control to datapath
  typedef struct packed {
    logic secTick;
    logic captureTime;
    logic captureDate;
    logic loadTime;
    logic loadDate;
  } calStrobe_t;

  function automatic logic [4:0] monthDays(input logic [3:0] month, input logic leap);
    case (month)
      4'd4, 4'd6, 4'd9, 4'd11: monthDays = 5'd30;
      4'd2:                    monthDays = leap ? 5'd29 : 5'd28;
      default:                 monthDays = 5'd31;
    endcase
  endfunction
endpackage

// File: rtl/cal_commit_seq.sv
module cal_commit_seq #(
  parameter int COMMIT_TICKS = 3
) (
  input  logic clk,
  input  logic rstN,
  input  logic wrReq,
  input  logic slowTick,
  output logic accept,
  output logic busy,
  output logic commit
);
  localparam int CNT_W = $clog2(COMMIT_TICKS + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(COMMIT_TICKS - 1);

  logic [CNT_W-1:0] tickCnt;

  assign accept = wrReq && !busy;
  assign commit = busy && slowTick && (tickCnt == LAST);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy    <= 1'b0;
      tickCnt <= '0;
    end else if (accept) begin
      busy    <= 1'b1;
      tickCnt <= '0;
    end else if (commit) begin
      busy    <= 1'b0;
      tickCnt <= '0;
    end else if (busy && slowTick) begin
      tickCnt <= tickCnt + 1'b1;
    end
  end
endmodule

// File: rtl/cal_ctrl.sv
module cal_ctrl
  import cal_pkg::*;
#(
  parameter int SLOW_PER_SEC = 32768,
  parameter int COMMIT_TICKS = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  input  logic              intOscEn,
  input  logic              extOscEn,
  input  calTime_t          curTime,
  input  calDate_t          curDate,
  output calStrobe_t        strobe,
  output logic [DATA_W-1:0] busRdata,
  output logic              extSel,
  output logic              timeBusy,
  output logic              dateBusy
);
  localparam int SEC_W = $clog2(SLOW_PER_SEC + 1);
  localparam logic [SEC_W-1:0] SEC_LAST = SEC_W'(SLOW_PER_SEC - 1);

  logic [PRESC_W-1:0] presc;
  logic [PRESC_W-1:0] intDiv;
  logic [SEC_W-1:0]   secDiv;
  logic               intTick;
  logic               slowTick;
  logic               prescWr;
  logic [1:0]         wrReq;
  logic [1:0]         accept;
  logic [1:0]         busy;
  logic [1:0]         commit;

  assign prescWr  = busWr && (busAddr == ADDR_PRESC);
  assign intTick  = !extSel && intOscEn && (intDiv >= presc);
  assign slowTick = extSel ? extOscEn : intTick;

  // guarded control word
  always_ff @(posedge clk) begin
    if (!rstN) begin
      extSel <= 1'b0;
      presc  <= '0;
    end else begin
      if (busWr && (busAddr == ADDR_CTRL) && (busWdata[31:16] == CTRL_KEY))
        extSel <= busWdata[0];
      if (prescWr)
        presc <= busWdata[PRESC_W-1:0];
    end
  end

  // internal oscillator divider and seconds divider
  always_ff @(posedge clk) begin
    if (!rstN) begin
      intDiv <= '0;
      secDiv <= '0;
    end else begin
      if (extSel || prescWr)       intDiv <= '0;
      else if (intTick)            intDiv <= '0;
      else if (intOscEn)           intDiv <= intDiv + 1'b1;
      if (slowTick)
        secDiv <= (secDiv == SEC_LAST) ? '0 : secDiv + 1'b1;
    end
  end

  assign wrReq[0] = busWr && (busAddr == ADDR_TIME);
  assign wrReq[1] = busWr && (busAddr == ADDR_DATE);

  for (genvar g = 0; g < 2; g++) begin : gSeq
    cal_commit_seq #(.COMMIT_TICKS(COMMIT_TICKS)) u_seq (
      .clk     (clk),
      .rstN    (rstN),
      .wrReq   (wrReq[g]),
      .slowTick(slowTick),
      .accept  (accept[g]),
      .busy    (busy[g]),
      .commit  (commit[g])
    );
  end

  assign timeBusy = busy[0];
  assign dateBusy = busy[1];

  always_comb begin
    strobe.secTick     = slowTick && (secDiv == SEC_LAST);
    strobe.captureTime = accept[0];
    strobe.captureDate = accept[1];
    strobe.loadTime    = commit[0];
    strobe.loadDate    = commit[1];
  end

  // registered readback
  always_ff @(posedge clk) begin
    if (!rstN) begin
      busRdata <= '0;
    end else if (busRd) begin
      case (busAddr)
        ADDR_CTRL:  busRdata <= {22'd0, 1'b0, timeBusy, dateBusy, 6'd0, extSel};
        ADDR_PRESC: busRdata <= {{(DATA_W-PRESC_W){1'b0}}, presc};
        ADDR_DATE:  busRdata <= {9'd0, curDate.leap, curDate.year, 4'd0,
                                 curDate.month, 3'd0, curDate.day};
        ADDR_TIME:  busRdata <= {11'd0, curTime.hour, 2'd0, curTime.min,
                                 2'd0, curTime.sec};
        default:    busRdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/cal_datapath.sv
module cal_datapath
  import cal_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  calStrobe_t        strobe,
  input  logic [DATA_W-1:0] busWdata,
  output calTime_t          curTime,
  output calDate_t          curDate
);
  calTime_t pendTime;
  calDate_t pendDate;
  calTime_t nextTime;
  calDate_t nextDate;
  logic     secWrap;
  logic     minWrap;
  logic     hourWrap;
  logic     dayCarry;
  logic     dayLast;
  logic     monthLast;
  logic [5:0] yearInc;
  logic     unusedWdata;

  assign unusedWdata = ^{busWdata[31:23], busWdata[15:14], busWdata[7:6]};

  assign secWrap   = curTime.sec == 6'd59;
  assign minWrap   = curTime.min == 6'd59;
  assign hourWrap  = curTime.hour == 5'd23;
  assign dayCarry  = strobe.secTick && !strobe.loadTime && secWrap && minWrap && hourWrap;
  assign dayLast   = curDate.day >= monthDays(curDate.month, curDate.leap);
  assign monthLast = curDate.month >= 4'd12;
  assign yearInc   = curDate.year + 6'd1;

  always_comb begin
    nextTime = curTime;
    if (strobe.secTick) begin
      if (secWrap) begin
        nextTime.sec = '0;
        if (minWrap) begin
          nextTime.min  = '0;
          nextTime.hour = hourWrap ? 5'd0 : curTime.hour + 5'd1;
        end else begin
          nextTime.min = curTime.min + 6'd1;
        end
      end else begin
        nextTime.sec = curTime.sec + 6'd1;
      end
    end
  end

  always_comb begin
    nextDate = curDate;
    if (dayCarry) begin
      if (dayLast) begin
        nextDate.day = 5'd1;
        if (monthLast) begin
          nextDate.month = 4'd1;
          nextDate.year  = yearInc;
          // (year + 1970) mod 4 == 0  <=>  year mod 4 == 2
          nextDate.leap  = yearInc[1:0] == 2'd2;
        end else begin
          nextDate.month = curDate.month + 4'd1;
        end
      end else begin
        nextDate.day = curDate.day + 5'd1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendTime <= '0;
      pendDate <= '0;
      curTime  <= '0;
      curDate  <= '{leap: 1'b0, year: 6'd0, month: 4'd1, day: 5'd1};
    end else begin
      if (strobe.captureTime)
        pendTime <= '{hour: busWdata[20:16], min: busWdata[13:8], sec: busWdata[5:0]};
      if (strobe.captureDate)
        pendDate <= '{leap: busWdata[22], year: busWdata[21:16],
                      month: busWdata[11:8], day: busWdata[4:0]};
      curTime <= strobe.loadTime ? pendTime : nextTime;
      curDate <= strobe.loadDate ? pendDate : nextDate;
    end
  end
endmodule

// File: rtl/cal_clock.sv
module cal_clock
  import cal_pkg::*;
#(
  parameter int SLOW_PER_SEC = 32768,
  parameter int COMMIT_TICKS = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic              intOscEn,
  input  logic              extOscEn
);
  calStrobe_t strobe;
  calTime_t   curTime;
  calDate_t   curDate;
  logic       extSel;
  logic       timeBusy;
  logic       dateBusy;

  cal_ctrl #(.SLOW_PER_SEC(SLOW_PER_SEC), .COMMIT_TICKS(COMMIT_TICKS)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .busWr   (busWr),
    .busRd   (busRd),
    .busAddr (busAddr),
    .busWdata(busWdata),
    .intOscEn(intOscEn),
    .extOscEn(extOscEn),
    .curTime (curTime),
    .curDate (curDate),
    .strobe  (strobe),
    .busRdata(busRdata),
    .extSel  (extSel),
    .timeBusy(timeBusy),
    .dateBusy(dateBusy)
  );

  cal_datapath u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .busWdata(busWdata),
    .curTime (curTime),
    .curDate (curDate)
  );
endmodule

// File: rtl/cal_clock_chk.sv
module cal_clock_chk
  import cal_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              busWr,
  input logic [ADDR_W-1:0] busAddr,
  input logic [DATA_W-1:0] busWdata,
  input logic              extSel,
  input logic              timeBusy,
  input logic              dateBusy,
  input calStrobe_t        strobe,
  input calTime_t          curTime,
  input calDate_t          curDate
);
  AST_KEY_GUARD: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr == ADDR_CTRL && busWdata[31:16] != CTRL_KEY) |=> $stable(extSel)); // R2

  AST_BUSY_RISE_FROM_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(timeBusy) |-> $past(busWr && busAddr == ADDR_TIME)); // R5

  AST_TIME_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (timeBusy && !strobe.loadTime) |=> timeBusy); // R6

  AST_TIME_COMMIT_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadTime |=> !timeBusy); // R6

  AST_DATE_COMMIT_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadDate |=> !dateBusy); // R6

  AST_SEC_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.secTick && !strobe.loadTime && curTime.sec != 6'd59)
      |=> curTime.sec == $past(curTime.sec) + 6'd1); // R8

  AST_MIN_CARRY: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.secTick && !strobe.loadTime && curTime.sec == 6'd59 && curTime.min != 6'd59)
      |=> (curTime.sec == 6'd0 && curTime.min == $past(curTime.min) + 6'd1)); // R8

  AST_DAY_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.secTick && !strobe.loadTime && !strobe.loadDate &&
     curTime.sec == 6'd59 && curTime.min == 6'd59 && curTime.hour == 5'd23 &&
     curDate.day == monthDays(curDate.month, curDate.leap))
      |=> curDate.day == 5'd1); // R9
endmodule

bind cal_clock cal_clock_chk u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .busWr   (busWr),
  .busAddr (busAddr),
  .busWdata(busWdata),
  .extSel  (extSel),
  .timeBusy(timeBusy),
  .dateBusy(dateBusy),
  .strobe  (strobe),
  .curTime (curTime),
  .curDate (curDate)
);

// File: tb/cal_clock_tb.sv
module cal_clock_tb;
  localparam int SPS = 4;
  localparam logic [31:0] KEY = 32'h16AA_0000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWr = 1'b0;
  logic        busRd = 1'b0;
  logic [7:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        intOscEn = 1'b0;
  logic        extOscEn = 1'b0;

  int checks = 0;
  int errors = 0;
  int phase = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  cal_clock #(.SLOW_PER_SEC(SPS), .COMMIT_TICKS(3)) u_dut (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busRd(busRd), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .intOscEn(intOscEn), .extOscEn(extOscEn)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); busWr = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk); busWr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); busRd = 1'b1; busAddr = a;
    @(negedge clk); busRd = 1'b0; d = busRdata;
  endtask

  task automatic extPulse(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); extOscEn = 1'b1;
      @(negedge clk); extOscEn = 1'b0;
      phase = (phase + 1) % SPS;
    end
  endtask

  task automatic intPulse(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); intOscEn = 1'b1;
      @(negedge clk); intOscEn = 1'b0;
    end
  endtask

  function automatic int mdays(input int m, input int lp);
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    if (m == 2) return lp ? 29 : 28;
    return 31;
  endfunction

  function automatic logic [31:0] packDate(input int d, input int m, input int y, input int lp);
    return (32'(lp) << 22) | (32'(y) << 16) | (32'(m) << 8) | 32'(d);
  endfunction

  // load time 23:59:59 and a date, then let one second elapse
  task automatic dayStep(input int d, input int m, input int y, input int lp);
    logic [31:0] v;
    int ed, em, ey, el;
    wr(8'h14, 32'h0017_3B3B);
    wr(8'h10, packDate(d, m, y, lp));
    extPulse(3);
    rd(8'h10, v); chk("R6 date load", v, packDate(d, m, y, lp));
    do extPulse(1); while (phase != 0);
    ed = d + 1; em = m; ey = y; el = lp;
    if (d >= mdays(m, lp)) begin
      ed = 1;
      if (m == 12) begin
        em = 1; ey = (y + 1) % 64; el = ((ey + 1970) % 4 == 0) ? 1 : 0;
      end else em = m + 1;
    end
    rd(8'h10, v);
    chk((m == 12 && d == 31) ? "R10 year step" : "R9 day step", v, packDate(ed, em, ey, el));
    rd(8'h14, v); chk("R8 midnight", v, 32'h0);
  endtask

  initial begin
    logic [31:0] v;
    int secs;
    repeat (4) @(negedge clk);
    rstN = 1'b1;

    rd(8'h00, v); chk("R1 ctrl", v, 32'h0);
    rd(8'h08, v); chk("R1 presc", v, 32'h0);
    rd(8'h14, v); chk("R1 time", v, 32'h0);
    rd(8'h10, v); chk("R1 R11 date", v, 32'h0000_0101);

    wr(8'h00, 32'h0000_0001); rd(8'h00, v); chk("R2 no key", v, 32'h0);
    wr(8'h00, 32'h16AB_0001); rd(8'h00, v); chk("R2 bad key", v, 32'h0);
    wr(8'h00, KEY | 32'h1);   rd(8'h00, v); chk("R2 key", v, 32'h1);

    intPulse(8); rd(8'h14, v); chk("R3 int ignored", v, 32'h0);
    extPulse(SPS - 1); rd(8'h14, v); chk("R4 before tick", v, 32'h0);
    extPulse(1); rd(8'h14, v); chk("R4 tick", v, 32'h1);
    extPulse(SPS); rd(8'h14, v); chk("R4 second tick", v, 32'h2);
    secs = 2;

    wr(8'h00, KEY); rd(8'h00, v); chk("R2 key clear", v, 32'h0);
    extPulse(SPS); rd(8'h14, v); chk("R3 ext ignored", v, 32'(secs));
    phase = 0;
    for (int p = 0; p < 4; p++) begin
      wr(8'h08, 32'hFFFF_FFE0 | 32'(p));
      rd(8'h08, v); chk("R3 presc readback", v, 32'(p));
      intPulse((p + 1) * SPS - 1);
      rd(8'h14, v); chk("R3 divided before", v, 32'(secs));
      intPulse(1); secs++;
      rd(8'h14, v); chk("R3 divided tick", v, 32'(secs));
    end
    wr(8'h00, KEY | 32'h1);

    // deferred commit
    wr(8'h14, 32'h0017_3B3A);
    rd(8'h00, v); chk("R5 time busy", v, 32'h0000_0101);
    wr(8'h14, 32'h000A_0A0A);
    extPulse(2);
    rd(8'h00, v); chk("R6 still busy", v, 32'h0000_0101);
    rd(8'h14, v); chk("R6 old value", v, 32'(secs));
    extPulse(1);
    rd(8'h00, v); chk("R6 busy cleared", v, 32'h1);
    rd(8'h14, v); chk("R7 first write wins", v, 32'h0017_3B3A);
    extPulse(1); rd(8'h14, v); chk("R8 sec step", v, 32'h0017_3B3B);
    wr(8'h10, packDate(5, 3, 2, 1));
    rd(8'h00, v); chk("R5 date busy", v, 32'h0000_0081);
    wr(8'h10, packDate(9, 9, 9, 0));
    extPulse(3);
    rd(8'h10, v); chk("R7 date ignore", v, packDate(5, 3, 2, 1));
    while (phase != 0) extPulse(1);
    rd(8'h14, v); chk("R8 hour wrap", v, 32'h0);
    rd(8'h10, v); chk("R8 day carry", v, packDate(6, 3, 2, 1));

    for (int m = 1; m <= 12; m++)
      for (int lp = 0; lp < 2; lp++)
        for (int off = 0; off < 2; off++)
          dayStep(mdays(m, lp) - off, m, lp ? 2 : 5, lp);
    dayStep(31, 12, 63, 0);
    dayStep(31, 12, 1, 0);
    dayStep(31, 12, 2, 1);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule